// File: doc/BRIEF.md
# Mining configuration and result register file

This block is the bus-facing register file of a hash-search accelerator. A host on a 32-bit Wishbone bus writes the block header, the target threshold, the first nonce of the search and a control word. The block drives those values straight out as wide configuration vectors to the search controller and the hash engine. When the engine reports a winning nonce, the block stores that nonce, raises a sticky found flag and asserts its interrupt line.

The host reads back the stored nonce, a status word and a constant identification word. Reading the control register also acknowledges the interrupt. Each bus request is answered by a registered acknowledge in the following cycle, and the read data arrives together with it. Every register is reset asynchronously to zero.

Top module: `miner_csr`

## Requirements
- R1: While `arst_i` is high and after it is released, `bus_ack_o`, `bus_rdat_o`, `irq_o`, every configuration output and every control output are zero until a bus write or a hit changes them.
- R2: Each clock cycle in which `bus_cyc_i` and `bus_stb_i` are both high produces `bus_ack_o` high in the next cycle only. A cycle without a request produces `bus_ack_o` low in the next cycle, so a request held for k cycles yields k acknowledge cycles.
- R3: The word index is `bus_adr_i[6:2]`, and read data appears on `bus_rdat_o` in the acknowledge cycle. Index 0 is nonce bits [31:0] and index 1 is nonce bits [63:32] of the stored solution. Index 2 is the status word. Index 3 always returns 32'h53484133, the ASCII characters "SHA3" with 'S' in bits [31:24].
- R4: Indices 4 to 11 are read/write and form `header_o`. Indices 12 to 19 form `target_o`, and indices 20 and 21 form `nonce_base_o`. In each group the lowest index holds bits [31:0], and each higher index holds the next 32 bits.
- R5: A write updates byte k (bits 8k+7 to 8k) of the addressed register only where `bus_sel_i[k]` is high. The other bytes keep their old value.
- R6: Index 22 is the control word. Bit 0 drives `run_o`, bit 1 drives `test_o`, bit 2 drives `halt_o`, bits [23:16] drive `pad_tail_o` and bits [31:24] drive `pad_head_o`. Bits [15:3] are not stored and always read as zero.
- R7: Writes to indices 0 to 3, to indices 23 to 31, or to any address with a nonzero bit in [1:0] or above bit 6 change no register. Reads of indices 23 to 31, and reads of such addresses, return zero.
- R8: A cycle with `hit_i` high stores `hit_nonce_i` as the solution and sets the found flag. `irq_o` is high from the next cycle on.
- R9: A read request to index 22 clears the found flag and `irq_o` at that clock edge, and the read still returns the control word. A hit in the same cycle takes priority and keeps them set. Writes to index 22 do not clear them.
- R10: The status word is {29'b0, `core_selftest_i`, `core_busy_i`, found flag}, with the two inputs sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| arst_i | input | 1 | Asynchronous reset, active high |
| bus_cyc_i | input | 1 | Bus cycle in progress |
| bus_stb_i | input | 1 | Request strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_sel_i | input | 4 | Byte lane enables |
| bus_adr_i | input | ADR_W | Byte address |
| bus_wdat_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Registered acknowledge |
| bus_rdat_o | output | 32 | Registered read data |
| hit_i | input | 1 | Engine reports a winning nonce |
| hit_nonce_i | input | 64 | The winning nonce |
| core_busy_i | input | 1 | Search is advancing (status bit 1) |
| core_selftest_i | input | 1 | Exact-match test in progress (status bit 2) |
| header_o | output | 256 | Block header to the hash engine |
| target_o | output | 256 | Threshold the hash is compared against |
| nonce_base_o | output | 64 | First nonce of the search |
| run_o | output | 1 | Search enable |
| test_o | output | 1 | Exact-match test mode |
| halt_o | output | 1 | Stop request |
| pad_tail_o | output | 8 | Closing padding byte |
| pad_head_o | output | 8 | Opening padding byte |
| irq_o | output | 1 | Solution interrupt |

## Verification
The properties assume the host never starts a request while `arst_i` is high. They also assume that `hit_i` is a clean synchronous pulse from the engine, and that the request signals are stable across each rising edge. The bench drives every bus signal and `hit_i` only on falling edges, keeps them at zero through reset, and samples results on the following falling edge. It raises `hit_i` only in cycles where the found-flag outcome is known, including the deliberate collision with a control-register read.

// File: rtl/miner_csr_pkg.sv
package miner_csr_pkg;
   localparam int WORD_W    = 32;
   localparam int LANES     = WORD_W / 8;
   localparam int IDX_W     = 5;
   localparam int IDX_LSB   = 2;
   localparam int SOL_WORDS = 2;
   localparam int HDR_WORDS = 8;
   localparam int TGT_WORDS = 8;
   localparam int NB_WORDS  = 2;

   localparam int IDX_STATUS = SOL_WORDS;
   localparam int IDX_ID     = IDX_STATUS + 1;
   localparam int IDX_HDR    = IDX_ID + 1;
   localparam int IDX_TGT    = IDX_HDR + HDR_WORDS;
   localparam int IDX_NB     = IDX_TGT + TGT_WORDS;
   localparam int IDX_CTL    = IDX_NB + NB_WORDS;
   localparam int RW_WORDS   = IDX_CTL - IDX_HDR + 1;

   localparam logic [WORD_W-1:0] CTL_KEEP = 32'hFFFF_0007;
   localparam logic [WORD_W-1:0] ID_WORD  = 32'h5348_4133;

   // Bits of writable word w (counted from IDX_HDR) that hold state.
   function automatic logic [WORD_W-1:0] keep_mask(input int w);
      return (w == IDX_CTL - IDX_HDR) ? CTL_KEEP : '1;
   endfunction
endpackage

// File: rtl/csr_rw_bank.sv
module csr_rw_bank
   import miner_csr_pkg::*;
#(
   parameter int N_WORDS = RW_WORDS,
   parameter int BASE    = IDX_HDR
) (
   input  logic                        clk_i,
   input  logic                        arst_i,
   input  logic                        wr_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic [LANES-1:0]            sel_i,
   input  logic [WORD_W-1:0]           wdat_i,
   output logic [N_WORDS*WORD_W-1:0]   q_o
);
   if (BASE + N_WORDS > (1 << IDX_W)) begin : g_range_bad
      $error("csr_rw_bank: words exceed index space");
   end

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      localparam logic [WORD_W-1:0] KEEP = keep_mask(w);
      logic hit_w;
      assign hit_w = wr_i && (idx_i == IDX_W'(BASE + w));

      for (genvar b = 0; b < LANES; b++) begin : g_lane
         logic [7:0] byte_q;
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i)
               byte_q <= '0;
            else if (hit_w && sel_i[b])
               byte_q <= wdat_i[8*b +: 8] & KEEP[8*b +: 8];
         end
         assign q_o[w*WORD_W + 8*b +: 8] = byte_q;
      end
   end
endmodule

// File: rtl/csr_sol_latch.sv
module csr_sol_latch
   import miner_csr_pkg::*;
(
   input  logic                          clk_i,
   input  logic                          arst_i,
   input  logic                          hit_i,
   input  logic [SOL_WORDS*WORD_W-1:0]   nonce_i,
   input  logic                          clr_i,
   output logic [SOL_WORDS*WORD_W-1:0]   sol_o,
   output logic                          flag_o
);
   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         sol_o  <= '0;
         flag_o <= 1'b0;
      end else begin
         if (hit_i) begin
            sol_o  <= nonce_i;
            flag_o <= 1'b1;
         end else if (clr_i) begin
            flag_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux
   import miner_csr_pkg::*;
(
   input  logic                          mapped_i,
   input  logic [IDX_W-1:0]              idx_i,
   input  logic [SOL_WORDS*WORD_W-1:0]   sol_i,
   input  logic                          flag_i,
   input  logic                          busy_i,
   input  logic                          selftest_i,
   input  logic [RW_WORDS*WORD_W-1:0]    bank_i,
   output logic [WORD_W-1:0]             word_o
);
   logic [IDX_W-1:0] off;
   assign off = idx_i - IDX_W'(IDX_HDR);

   always_comb begin
      word_o = '0;
      if (mapped_i) begin
         if (int'(idx_i) < SOL_WORDS)
            word_o = sol_i[int'(idx_i)*WORD_W +: WORD_W];
         else if (int'(idx_i) == IDX_STATUS)
            word_o = {{(WORD_W-3){1'b0}}, selftest_i, busy_i, flag_i};
         else if (int'(idx_i) == IDX_ID)
            word_o = ID_WORD;
         else if (int'(idx_i) <= IDX_CTL)
            word_o = bank_i[int'(off)*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/miner_csr.sv
module miner_csr
   import miner_csr_pkg::*;
#(
   parameter int ADR_W        = 32,
   parameter bit IDLE_ZERO_RD = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          arst_i,
   input  logic                          bus_cyc_i,
   input  logic                          bus_stb_i,
   input  logic                          bus_we_i,
   input  logic [LANES-1:0]              bus_sel_i,
   input  logic [ADR_W-1:0]              bus_adr_i,
   input  logic [WORD_W-1:0]             bus_wdat_i,
   output logic                          bus_ack_o,
   output logic [WORD_W-1:0]             bus_rdat_o,
   input  logic                          hit_i,
   input  logic [SOL_WORDS*WORD_W-1:0]   hit_nonce_i,
   input  logic                          core_busy_i,
   input  logic                          core_selftest_i,
   output logic [HDR_WORDS*WORD_W-1:0]   header_o,
   output logic [TGT_WORDS*WORD_W-1:0]   target_o,
   output logic [NB_WORDS*WORD_W-1:0]    nonce_base_o,
   output logic                          run_o,
   output logic                          test_o,
   output logic                          halt_o,
   output logic [7:0]                    pad_tail_o,
   output logic [7:0]                    pad_head_o,
   output logic                          irq_o
);
   localparam int IDX_HI = IDX_LSB + IDX_W;

   if (ADR_W <= IDX_HI) begin : g_adr_bad
      $error("miner_csr: ADR_W must exceed the index field");
   end
   if (IDX_CTL >= (1 << IDX_W)) begin : g_map_bad
      $error("miner_csr: register map exceeds index space");
   end
   if (WORD_W != 32) begin : g_word_bad
      $error("miner_csr: only 32-bit words are supported");
   end

   logic                        req, mapped, wr_en, ctl_rd, flag;
   logic [IDX_W-1:0]            idx;
   logic [WORD_W-1:0]           rd_word;
   logic [RW_WORDS*WORD_W-1:0]  bank_q;
   logic [SOL_WORDS*WORD_W-1:0] sol_q;

   assign req    = bus_cyc_i && bus_stb_i;
   assign idx    = bus_adr_i[IDX_HI-1:IDX_LSB];
   assign mapped = (bus_adr_i[IDX_LSB-1:0] == '0) && (bus_adr_i[ADR_W-1:IDX_HI] == '0);
   assign wr_en  = req && bus_we_i && mapped;
   assign ctl_rd = req && !bus_we_i && mapped && (idx == IDX_W'(IDX_CTL));

   csr_rw_bank #(.N_WORDS(RW_WORDS), .BASE(IDX_HDR)) u_bank (
      .clk_i  (clk_i),
      .arst_i (arst_i),
      .wr_i   (wr_en),
      .idx_i  (idx),
      .sel_i  (bus_sel_i),
      .wdat_i (bus_wdat_i),
      .q_o    (bank_q)
   );

   csr_sol_latch u_sol (
      .clk_i   (clk_i),
      .arst_i  (arst_i),
      .hit_i   (hit_i),
      .nonce_i (hit_nonce_i),
      .clr_i   (ctl_rd),
      .sol_o   (sol_q),
      .flag_o  (flag)
   );

   csr_rd_mux u_rd (
      .mapped_i   (mapped),
      .idx_i      (idx),
      .sol_i      (sol_q),
      .flag_i     (flag),
      .busy_i     (core_busy_i),
      .selftest_i (core_selftest_i),
      .bank_i     (bank_q),
      .word_o     (rd_word)
   );

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) bus_ack_o <= 1'b0;
      else        bus_ack_o <= req;
   end

   if (IDLE_ZERO_RD) begin : g_rd_zero
      always_ff @(posedge clk_i or posedge arst_i) begin
         if (arst_i)   bus_rdat_o <= '0;
         else if (req) bus_rdat_o <= rd_word;
         else          bus_rdat_o <= '0;
      end
   end else begin : g_rd_hold
      always_ff @(posedge clk_i or posedge arst_i) begin
         if (arst_i)   bus_rdat_o <= '0;
         else if (req) bus_rdat_o <= rd_word;
      end
   end

   assign header_o     = bank_q[(IDX_HDR - IDX_HDR)*WORD_W +: HDR_WORDS*WORD_W];
   assign target_o     = bank_q[(IDX_TGT - IDX_HDR)*WORD_W +: TGT_WORDS*WORD_W];
   assign nonce_base_o = bank_q[(IDX_NB  - IDX_HDR)*WORD_W +: NB_WORDS*WORD_W];
   assign run_o        = bank_q[(IDX_CTL - IDX_HDR)*WORD_W + 0];
   assign test_o       = bank_q[(IDX_CTL - IDX_HDR)*WORD_W + 1];
   assign halt_o       = bank_q[(IDX_CTL - IDX_HDR)*WORD_W + 2];
   assign pad_tail_o   = bank_q[(IDX_CTL - IDX_HDR)*WORD_W + 16 +: 8];
   assign pad_head_o   = bank_q[(IDX_CTL - IDX_HDR)*WORD_W + 24 +: 8];
   assign irq_o        = flag;
endmodule

// File: rtl/miner_csr_chk.sv
module miner_csr_chk
   import miner_csr_pkg::*;
#(
   parameter int ADR_W = 32
) (
   input logic                         clk_i,
   input logic                         arst_i,
   input logic                         bus_cyc_i,
   input logic                         bus_stb_i,
   input logic                         bus_we_i,
   input logic [ADR_W-1:0]             bus_adr_i,
   input logic                         bus_ack_o,
   input logic [WORD_W-1:0]            bus_rdat_o,
   input logic                         hit_i,
   input logic                         irq_o,
   input logic [HDR_WORDS*WORD_W-1:0]  header_o,
   input logic [TGT_WORDS*WORD_W-1:0]  target_o,
   input logic [NB_WORDS*WORD_W-1:0]   nonce_base_o
);
   logic             rq, ok_adr;
   logic [IDX_W-1:0] ix;
   assign rq     = bus_cyc_i && bus_stb_i;
   assign ix     = bus_adr_i[IDX_LSB+IDX_W-1:IDX_LSB];
   assign ok_adr = (bus_adr_i[IDX_LSB-1:0] == '0) && (bus_adr_i[ADR_W-1:IDX_LSB+IDX_W] == '0);

   // R2
   ack_follow_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      rq |=> bus_ack_o);
   // R2
   ack_idle_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      !rq |=> !bus_ack_o);
   // R3
   id_word_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      (rq && !bus_we_i && ok_adr && ix == IDX_W'(IDX_ID)) |=> (bus_rdat_o == ID_WORD));
   // R8
   irq_set_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      hit_i |=> irq_o);
   // R8
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      $rose(irq_o) |-> $past(hit_i));
   // R9
   irq_clear_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      (rq && !bus_we_i && ok_adr && ix == IDX_W'(IDX_CTL) && !hit_i) |=> !irq_o);
   // R4
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      !(rq && bus_we_i) |=> ($stable(header_o) && $stable(target_o) && $stable(nonce_base_o)));
   // R7
   ro_write_chk: assert property (@(posedge clk_i) disable iff (arst_i)
      (rq && bus_we_i && (!ok_adr || ix < IDX_W'(IDX_HDR) || ix > IDX_W'(IDX_CTL)))
      |=> ($stable(header_o) && $stable(target_o) && $stable(nonce_base_o)));
endmodule

bind miner_csr miner_csr_chk #(.ADR_W(ADR_W)) u_chk (
   .clk_i        (clk_i),
   .arst_i       (arst_i),
   .bus_cyc_i    (bus_cyc_i),
   .bus_stb_i    (bus_stb_i),
   .bus_we_i     (bus_we_i),
   .bus_adr_i    (bus_adr_i),
   .bus_ack_o    (bus_ack_o),
   .bus_rdat_o   (bus_rdat_o),
   .hit_i        (hit_i),
   .irq_o        (irq_o),
   .header_o     (header_o),
   .target_o     (target_o),
   .nonce_base_o (nonce_base_o)
);

// File: tb/miner_csr_tb.sv
module miner_csr_tb;
   logic         clk = 1'b0;
   logic         arst = 1'b1;
   logic         cyc = 0, stb = 0, we = 0;
   logic [3:0]   sel = 0;
   logic [31:0]  adr = 0, wdat = 0;
   logic         ack;
   logic [31:0]  rdat;
   logic         hit = 0, busy = 0, stest = 0;
   logic [63:0]  hnonce = 0;
   logic [255:0] hdr, tgt;
   logic [63:0]  nbase;
   logic         run, tst, hlt, irq;
   logic [7:0]   ptail, phead;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] m [0:31];
   logic [63:0] sol_m = 0;

   always #5 clk = ~clk;

   miner_csr u_dut (
      .clk_i(clk), .arst_i(arst), .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
      .bus_sel_i(sel), .bus_adr_i(adr), .bus_wdat_i(wdat), .bus_ack_o(ack),
      .bus_rdat_o(rdat), .hit_i(hit), .hit_nonce_i(hnonce), .core_busy_i(busy),
      .core_selftest_i(stest), .header_o(hdr), .target_o(tgt), .nonce_base_o(nbase),
      .run_o(run), .test_o(tst), .halt_o(hlt), .pad_tail_o(ptail), .pad_head_o(phead),
      .irq_o(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus(input logic w, input logic [31:0] a, input logic [3:0] s,
                      input logic [31:0] d, output logic [31:0] r, output logic k);
      @(negedge clk);
      cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
      @(negedge clk);
      r = rdat; k = ack;
      cyc = 0; stb = 0; we = 0;
   endtask

   function automatic logic [31:0] expect_rd(input int i);
      if (i == 0) return sol_m[31:0];
      if (i == 1) return sol_m[63:32];
      if (i == 2) return {29'b0, stest, busy, irq};
      if (i == 3) return 32'h5348_4133;
      if (i >= 4 && i <= 22) return m[i];
      return 32'h0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic        k;
      for (int i = 0; i < 32; i++) m[i] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ack == 0 && rdat == 0 && irq == 0, "R1 bus/irq in reset", {ack, rdat, irq}, 0);
      arst = 0;
      @(negedge clk);
      chk(hdr == 0 && tgt == 0 && nbase == 0, "R1 config outputs", hdr ^ tgt ^ {192'b0, nbase}, 0);
      chk({run, tst, hlt, ptail, phead} == 0, "R1 control outputs", {run, tst, hlt, ptail, phead}, 0);

      // R3 identification word, R10 status inputs
      bus(0, 3 << 2, 4'hF, 0, r, k);
      chk(r == 32'h5348_4133 && k, "R3 id word", r, 32'h5348_4133);
      busy = 1; stest = 0;
      bus(0, 2 << 2, 4'hF, 0, r, k);
      chk(r == 32'h2, "R10 status busy", r, 32'h2);
      busy = 0; stest = 1;
      bus(0, 2 << 2, 4'hF, 0, r, k);
      chk(r == 32'h4, "R10 status selftest", r, 32'h4);
      stest = 0;

      // R5 / R6 / R2: every writable word under every lane mask
      for (int i = 4; i <= 22; i++) begin
         for (int s = 0; s < 16; s++) begin
            logic [31:0] d, keep;
            d = (i * 32'h1F2E_3D4C) ^ (s * 32'h0A0B_0C0D) ^ 32'hA5A5_5A5A;
            keep = (i == 22) ? 32'hFFFF_0007 : 32'hFFFF_FFFF;
            for (int b = 0; b < 4; b++)
               if (s[b]) m[i][8*b +: 8] = d[8*b +: 8] & keep[8*b +: 8];
            bus(1, i << 2, s[3:0], d, r, k);
            chk(k == 1, "R2 write ack", k, 1);
            bus(0, i << 2, 4'h0, 0, r, k);
            chk(r == m[i], (i == 22) ? "R6 control readback" : "R5 lane write readback", r, m[i]);
         end
      end

      // R4 word order on configuration outputs, R6 control fields
      for (int w = 0; w < 8; w++) begin
         chk(hdr[32*w +: 32] == m[4 + w], "R4 header word", hdr[32*w +: 32], m[4 + w]);
         chk(tgt[32*w +: 32] == m[12 + w], "R4 target word", tgt[32*w +: 32], m[12 + w]);
      end
      chk(nbase == {m[21], m[20]}, "R4 nonce base", nbase, {m[21], m[20]});
      chk({phead, ptail, hlt, tst, run} == {m[22][31:16], m[22][2:0]}, "R6 control outputs",
          {phead, ptail, hlt, tst, run}, {m[22][31:16], m[22][2:0]});

      // R7 writes to read-only / unmapped words, reads of unmapped words
      for (int i = 0; i < 32; i++) begin
         if (i < 4 || i > 22) begin
            bus(1, i << 2, 4'hF, 32'hFFFF_FFFF, r, k);
            bus(0, i << 2, 4'hF, 0, r, k);
            chk(r == expect_rd(i), "R7 read-only or unmapped", r, expect_rd(i));
         end
      end
      bus(1, (4 << 2) | 1, 4'hF, 32'h1234_5678, r, k);
      bus(1, 32'h100 | (5 << 2), 4'hF, 32'h1234_5678, r, k);
      bus(0, 32'h100 | (5 << 2), 4'hF, 0, r, k);
      chk(r == 0, "R7 out-of-window read", r, 0);
      chk(hdr[31:0] == m[4] && hdr[63:32] == m[5], "R7 stray writes ignored", hdr[63:0], {m[5], m[4]});

      // R2 request held for three cycles
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = 3 << 2;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(ack == 1, "R2 held request ack", ack, 1);
      end
      cyc = 0; stb = 0;
      @(negedge clk);
      chk(ack == 0, "R2 ack drops", ack, 0);

      // R8 solution capture
      hit = 1; hnonce = 64'hDEAD_BEEF_0123_4567;
      @(negedge clk);
      hit = 0; sol_m = hnonce; hnonce = 0;
      chk(irq == 1, "R8 irq raised", irq, 1);
      bus(0, 0, 4'hF, 0, r, k);
      chk(r == 32'h0123_4567, "R8 solution low", r, 32'h0123_4567);
      bus(0, 1 << 2, 4'hF, 0, r, k);
      chk(r == 32'hDEAD_BEEF, "R8 solution high", r, 32'hDEAD_BEEF);
      bus(0, 2 << 2, 4'hF, 0, r, k);
      chk(r == 32'h1, "R8 found status", r, 32'h1);

      // R9 write to control keeps irq, read clears it
      bus(1, 22 << 2, 4'hF, m[22], r, k);
      chk(irq == 1, "R9 control write keeps irq", irq, 1);
      bus(0, 22 << 2, 4'hF, 0, r, k);
      chk(irq == 0 && r == m[22], "R9 control read clears irq", {irq, r}, {1'b0, m[22]});
      bus(0, 2 << 2, 4'hF, 0, r, k);
      chk(r == 32'h0, "R9 found status cleared", r, 0);

      // R9 hit collides with control read: hit wins
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = 22 << 2; hit = 1; hnonce = 64'h5;
      @(negedge clk);
      cyc = 0; stb = 0; hit = 0; sol_m = 64'h5;
      chk(irq == 1, "R9 hit beats clear", irq, 1);
      bus(0, 0, 4'hF, 0, r, k);
      chk(r == 32'h5, "R8 second solution", r, 32'h5);
      bus(0, 22 << 2, 4'hF, 0, r, k);
      chk(irq == 0, "R9 later clear", irq, 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule